// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking a multi-level radix tree held in memory. A translation begins with a one-cycle `start` pulse that carries the address, the kind of access (load, store or fetch), the two relocation-enable bits, the current process identifier and the partition-level word. The partition-level word locates the process table. If relocation is off for the access kind, the block answers at once with a real-mode result. Otherwise the top two address bits choose the quadrant. The quadrant decides which process identifier indexes the process table. The selected process entry names the root of a tree. The tree is then walked one level at a time, and each level supplies the number of index bits used at the next level.

All memory traffic goes through one read port that carries a single request at a time. The request side has a valid/ready handshake, and each accepted request returns one 8-byte response. A walk ends with a one-cycle `done` or a one-cycle `fault`. On `done` the block presents the real address, the page size as a power of two, the leaf entry and the address that leaf was read from. The companion permission checker takes the leaf entry from there. On `fault` the block presents a fault class, a cause word and the recorded address.

Top module: `radix_walker`

## Requirements
- R1: When a fetch (access code 2) starts with `ir_en` low, or a data access (any other code) starts with `dr_en` low, `done` rises in the next cycle with `real_mode` high. `real_addr` then equals the effective address with bits 63:60 cleared, and no memory read is made.
- R2: With relocation on, quadrant 1 or 2 (address bits 63:62 equal to 01 or 10) ends in a fault with no memory read and cause 0. For a fetch the fault class is 3 (instruction segment) and the recorded address is 0. For a load or store the class is 2 (data segment) and the recorded address is the effective address.
- R3: Quadrant 0 indexes the process table with the `pid` input. Quadrant 3 indexes it with identifier 0. The process entry is read at (partition word AND 0x0FFFFFFFFFFFF000) + 16 × identifier.
- R4: The process table holds 2^(partition bits 4:0 + 12) bytes. When 16 × identifier is at least that size, the walk ends in a storage fault with cause 0x40000000 and no memory read is made.
- R5: From the process entry, the root base is the entry AND 0x0FFFFFFFFFFFFF00 and the root index width is bits 4:0. The translated size in bits is ({bits 62:61, bits 7:5} as a 5-bit number) + 31.
- R6: At each level the walk uses the effective address with bits 63:62 cleared. It forms the index (EA >> (remaining − width)) AND (2^width − 1) and reads at base + 8 × index. It then subtracts the width from the remaining size.
- R7: When a level's index width is below 5, or larger than the remaining size, the walk ends in a storage fault with cause 0x00080000 before that level is read.
- R8: An entry whose bit 63 is clear ends the walk in a storage fault with cause 0x40000000. A valid entry with bit 62 clear supplies the next base and width through the same masks as the root.
- R9: A valid entry with bit 62 set ends the walk with `done`. `page_shift` is the remaining size S. `real_addr` is (entry AND 0x01FFFFFFFFFFF000) with bits below S cleared, ORed with the low S bits of the effective address. `leaf_pte` is the entry and `leaf_addr` is the address it was read from.
- R10: Storage faults have class 0 for loads and stores and class 1 for fetches. A store adds 0x02000000 to the cause. Data storage faults record the effective address, and fetch storage faults record 0.
- R11: `done` and `fault` are never high together. Each lasts exactly one cycle, after which the block is idle. A request held without `mem_req_ready` keeps its address. At most one read is outstanding.
- R12: The walk reads at most 8 directory or table levels. When a ninth level would be needed, it ends in a storage fault with cause 0x00080000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation; sampled only while idle |
| ea | input | 64 | Effective address |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| ir_en | input | 1 | Instruction relocation enable |
| dr_en | input | 1 | Data relocation enable |
| pid | input | PID_W | Current process identifier |
| part_entry | input | 64 | Partition word holding process-table base and size |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle successful completion |
| real_mode | output | 1 | Result came from real mode (full access) |
| real_addr | output | 64 | Translated address |
| page_shift | output | 7 | log2 of the page size |
| leaf_pte | output | 64 | Leaf entry that mapped the page |
| leaf_addr | output | 64 | Address of that leaf entry |
| fault | output | 1 | One-cycle fault completion |
| fault_kind | output | 2 | 0 data storage, 1 instruction storage, 2 data segment, 3 instruction segment |
| fault_cause | output | 32 | Cause word |
| fault_addr | output | 64 | Recorded faulting address |

## Verification
The bench builds several trees in a memory model, each with a different index width at each level. It then sweeps addresses through them for every access kind and compares each result with an arithmetic model of the walk. The hard cases are the shift arithmetic at unusual widths, the quadrant-3 identifier substitution, and the bounds check at exactly the table size. An off-by-one in any of these would return a wrong real address, or read the wrong process entry and mis-report a fault. Trees with a level width of 4, with a width larger than the remaining size, and with exactly 8 or 9 levels separate a correct level limit from one that loops forever or stops one level early. Store and fetch faults are compared for the store bit and the recorded address, because an error there shows only in the cause word.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

  localparam logic [63:0] PRT_BASE_MASK = 64'h0FFF_FFFF_FFFF_F000;
  localparam logic [63:0] NEXT_BASE_MASK = 64'h0FFF_FFFF_FFFF_FF00;
  localparam logic [63:0] PAGE_NUM_MASK = 64'h01FF_FFFF_FFFF_F000;
  localparam logic [63:0] WALK_EA_MASK = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] REAL_EA_MASK = 64'h0FFF_FFFF_FFFF_FFFF;

  localparam logic [31:0] CAUSE_NO_ENTRY = 32'h4000_0000;
  localparam logic [31:0] CAUSE_BAD_CFG = 32'h0008_0000;
  localparam logic [31:0] CAUSE_STORE = 32'h0200_0000;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef enum logic [1:0] {
    FK_DSTOR = 2'd0,
    FK_ISTOR = 2'd1,
    FK_DSEG  = 2'd2,
    FK_ISEG  = 2'd3
  } fault_kind_e;

  // translated size in bits from a process entry
  function automatic logic [6:0] tree_bits(input logic [63:0] d);
    return {2'b00, d[62:61], d[7:5]} + 7'd31;
  endfunction

  // index of one level
  function automatic logic [63:0] level_index(input logic [63:0] ea, input logic [6:0] rem,
                                              input logic [4:0] nls);
    logic [6:0] sh;
    sh = rem - {2'b00, nls};
    return (ea >> sh) & ((64'd1 << nls) - 64'd1);
  endfunction

  // process-table bounds test
  function automatic logic table_fits(input logic [63:0] off, input logic [4:0] prts);
    return off < (64'd1 << ({2'b00, prts} + 7'd12));
  endfunction

  // leaf address formation
  function automatic logic [63:0] leaf_real(input logic [63:0] pte, input logic [63:0] ea,
                                            input logic [6:0] sh);
    logic [63:0] low;
    low = (64'd1 << sh) - 64'd1;
    return ((pte & PAGE_NUM_MASK) & ~low) | (ea & low);
  endfunction

  function automatic fault_kind_e stor_kind(input logic [1:0] acc);
    return (acc == ACC_FETCH) ? FK_ISTOR : FK_DSTOR;
  endfunction

  function automatic logic [31:0] stor_cause(input logic [1:0] acc, input logic [31:0] c);
    return (acc == ACC_STORE) ? (c | CAUSE_STORE) : c;
  endfunction

  function automatic logic [63:0] stor_addr(input logic [1:0] acc, input logic [63:0] ea);
    return (acc == ACC_FETCH) ? 64'd0 : ea;
  endfunction

endpackage

// File: rtl/radix_front.sv
module radix_front
  import radix_walk_pkg::*;
#(
  parameter int PID_W = 20
) (
  input  logic [63:0]      ea,
  input  logic [1:0]       acc,
  input  logic             ir_en,
  input  logic             dr_en,
  input  logic [PID_W-1:0] pid,
  input  logic [63:0]      part_entry,
  output logic             real_hit,
  output logic             seg_hit,
  output logic             prt_oob,
  output logic [63:0]      prt_addr
);
  logic [1:0]       quad;
  logic [PID_W-1:0] pid_sel;
  logic [63:0]      prt_off;
  logic [63:0]      part_low;

  assign quad     = ea[63:62];
  assign real_hit = (acc == ACC_FETCH) ? !ir_en : !dr_en;
  assign seg_hit  = !real_hit && (quad == 2'b01 || quad == 2'b10);
  assign pid_sel  = (quad == 2'b11) ? '0 : pid;
  assign prt_off  = 64'(pid_sel) << 4;
  assign part_low = part_entry & 64'h1F;
  assign prt_oob  = !table_fits(prt_off, part_low[4:0]);
  assign prt_addr = (part_entry & PRT_BASE_MASK) + prt_off;
endmodule

// File: rtl/radix_level.sv
module radix_level
  import radix_walk_pkg::*;
#(
  parameter int MAX_LEVELS = 8,
  parameter int LVL_W = 4
) (
  input  logic [63:0]      ea_walk,
  input  logic [63:0]      base,
  input  logic [4:0]       nls,
  input  logic [6:0]       rem,
  input  logic [LVL_W-1:0] lvl,
  output logic             cfg_bad,
  output logic [63:0]      ent_addr
);
  logic width_small;
  logic width_big;
  logic too_deep;

  assign width_small = nls < 5'd5;
  assign width_big   = {2'b00, nls} > rem;
  assign too_deep    = lvl >= LVL_W'(MAX_LEVELS);
  assign cfg_bad     = width_small || width_big || too_deep;
  assign ent_addr    = base + (level_index(ea_walk, rem, nls) << 3);
endmodule

// File: rtl/radix_leaf.sv
module radix_leaf
  import radix_walk_pkg::*;
(
  input  logic [63:0] pte,
  input  logic [63:0] ea_walk,
  input  logic [6:0]  sh,
  output logic [63:0] real_addr
);
  assign real_addr = leaf_real(pte, ea_walk, sh);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import radix_walk_pkg::*;
#(
  parameter int PID_W = 20,
  parameter int MAX_LEVELS = 8,
  localparam int LVL_W = $clog2(MAX_LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      ea,
  input  logic [1:0]       acc,
  input  logic             ir_en,
  input  logic             dr_en,
  input  logic [PID_W-1:0] pid,
  input  logic [63:0]      part_entry,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             busy,
  output logic             done,
  output logic             real_mode,
  output logic [63:0]      real_addr,
  output logic [6:0]       page_shift,
  output logic [63:0]      leaf_pte,
  output logic [63:0]      leaf_addr,
  output logic             fault,
  output logic [1:0]       fault_kind,
  output logic [31:0]      fault_cause,
  output logic [63:0]      fault_addr
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRT_REQ, ST_PRT_WAIT, ST_DIR_REQ, ST_DIR_WAIT, ST_DONE, ST_FAULT
  } state_e;

  state_e           state;
  logic [63:0]      ea_q;
  logic [1:0]       acc_q;
  logic [63:0]      prt_addr_q;
  logic [63:0]      base_q;
  logic [4:0]       nls_q;
  logic [6:0]       rem_q;
  logic [LVL_W-1:0] lvl_q;
  logic [63:0]      ent_addr_q;
  logic             real_mode_q;
  logic [63:0]      real_addr_q;
  logic [6:0]       page_shift_q;
  logic [63:0]      leaf_pte_q;
  logic [63:0]      leaf_addr_q;
  fault_kind_e      fault_kind_q;
  logic [31:0]      fault_cause_q;
  logic [63:0]      fault_addr_q;

  // named internal events
  logic        ev_real;
  logic        ev_seg;
  logic        ev_oob;
  logic [63:0] prt_addr;
  logic        ev_cfg_bad;
  logic [63:0] ent_addr;
  logic [63:0] ea_walk;
  logic [6:0]  rem_after;
  logic [63:0] leaf_ra;
  logic        ev_rsp_invalid;
  logic        ev_rsp_leaf;

  assign ea_walk        = ea_q & WALK_EA_MASK;
  assign rem_after      = rem_q - {2'b00, nls_q};
  assign ev_rsp_invalid = !mem_rsp_data[63];
  assign ev_rsp_leaf    = mem_rsp_data[62];

  radix_front #(.PID_W(PID_W)) u_front (
    .ea(ea), .acc(acc), .ir_en(ir_en), .dr_en(dr_en), .pid(pid), .part_entry(part_entry),
    .real_hit(ev_real), .seg_hit(ev_seg), .prt_oob(ev_oob), .prt_addr(prt_addr)
  );

  radix_level #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)) u_level (
    .ea_walk(ea_walk), .base(base_q), .nls(nls_q), .rem(rem_q), .lvl(lvl_q),
    .cfg_bad(ev_cfg_bad), .ent_addr(ent_addr)
  );

  radix_leaf u_leaf (
    .pte(mem_rsp_data), .ea_walk(ea_walk), .sh(rem_after), .real_addr(leaf_ra)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      ea_q          <= '0;
      acc_q         <= '0;
      prt_addr_q    <= '0;
      base_q        <= '0;
      nls_q         <= '0;
      rem_q         <= '0;
      lvl_q         <= '0;
      ent_addr_q    <= '0;
      real_mode_q   <= 1'b0;
      real_addr_q   <= '0;
      page_shift_q  <= '0;
      leaf_pte_q    <= '0;
      leaf_addr_q   <= '0;
      fault_kind_q  <= FK_DSTOR;
      fault_cause_q <= '0;
      fault_addr_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          ea_q        <= ea;
          acc_q       <= acc;
          prt_addr_q  <= prt_addr;
          real_mode_q <= 1'b0;
          if (ev_real) begin
            real_mode_q  <= 1'b1;
            real_addr_q  <= ea & REAL_EA_MASK;
            page_shift_q <= '0;
            leaf_pte_q   <= '0;
            leaf_addr_q  <= '0;
            state        <= ST_DONE;
          end else if (ev_seg) begin
            fault_kind_q  <= (acc == ACC_FETCH) ? FK_ISEG : FK_DSEG;
            fault_cause_q <= '0;
            fault_addr_q  <= (acc == ACC_FETCH) ? 64'd0 : ea;
            state         <= ST_FAULT;
          end else if (ev_oob) begin
            fault_kind_q  <= stor_kind(acc);
            fault_cause_q <= stor_cause(acc, CAUSE_NO_ENTRY);
            fault_addr_q  <= stor_addr(acc, ea);
            state         <= ST_FAULT;
          end else begin
            state <= ST_PRT_REQ;
          end
        end
        ST_PRT_REQ: if (mem_req_ready) state <= ST_PRT_WAIT;
        ST_PRT_WAIT: if (mem_rsp_valid) begin
          base_q <= mem_rsp_data & NEXT_BASE_MASK;
          nls_q  <= mem_rsp_data[4:0];
          rem_q  <= tree_bits(mem_rsp_data);
          lvl_q  <= '0;
          state  <= ST_DIR_REQ;
        end
        ST_DIR_REQ: begin
          if (ev_cfg_bad) begin
            fault_kind_q  <= stor_kind(acc_q);
            fault_cause_q <= stor_cause(acc_q, CAUSE_BAD_CFG);
            fault_addr_q  <= stor_addr(acc_q, ea_q);
            state         <= ST_FAULT;
          end else if (mem_req_ready) begin
            ent_addr_q <= ent_addr;
            state      <= ST_DIR_WAIT;
          end
        end
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (ev_rsp_invalid) begin
            fault_kind_q  <= stor_kind(acc_q);
            fault_cause_q <= stor_cause(acc_q, CAUSE_NO_ENTRY);
            fault_addr_q  <= stor_addr(acc_q, ea_q);
            state         <= ST_FAULT;
          end else if (ev_rsp_leaf) begin
            real_addr_q  <= leaf_ra;
            page_shift_q <= rem_after;
            leaf_pte_q   <= mem_rsp_data;
            leaf_addr_q  <= ent_addr_q;
            state        <= ST_DONE;
          end else begin
            base_q <= mem_rsp_data & NEXT_BASE_MASK;
            nls_q  <= mem_rsp_data[4:0];
            rem_q  <= rem_after;
            lvl_q  <= lvl_q + 1'b1;
            state  <= ST_DIR_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_PRT_REQ) || (state == ST_DIR_REQ && !ev_cfg_bad);
  assign mem_req_addr  = (state == ST_DIR_REQ) ? ent_addr : prt_addr_q;
  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_DONE);
  assign fault         = (state == ST_FAULT);
  assign real_mode     = real_mode_q;
  assign real_addr     = real_addr_q;
  assign page_shift    = page_shift_q;
  assign leaf_pte      = leaf_pte_q;
  assign leaf_addr     = leaf_addr_q;
  assign fault_kind    = fault_kind_q;
  assign fault_cause   = fault_cause_q;
  assign fault_addr    = fault_addr_q;

  // R11: completion signals are exclusive and single-cycle
  assert_end_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  assert_end_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));
  // R11: a stalled request keeps its address
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R11: responses arrive only while one is awaited
  assert_rsp_expected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (state == ST_PRT_WAIT || state == ST_DIR_WAIT));
  // R12: level counter never passes the limit
  assert_level_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(MAX_LEVELS));
  // R10: store bit only on data storage faults
  assert_store_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_kind_q != FK_DSTOR) |-> (fault_cause_q[25] == 1'b0));
  // R1: real-mode results carry cleared top bits
  assert_real_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && real_mode_q) |-> (real_addr_q[63:60] == 4'h0));
endmodule

// File: tb/test_radix_walker.sv
module test_radix_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PRT_BASE = 64'h0000_0000_0010_0000;
  localparam logic [63:0] RPN_M = 64'h01FF_FFFF_FFFF_F000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] ea = '0;
  logic [1:0] acc = '0;
  logic ir_en = 1'b1, dr_en = 1'b1;
  logic [19:0] pid = '0;
  logic [63:0] part = '0;
  logic mem_req_valid, mem_rsp_valid = 1'b0, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr, mem_rsp_data = '0;
  logic busy, done, real_mode, fault;
  logic [63:0] real_addr, leaf_pte, leaf_addr, fault_addr;
  logic [6:0] page_shift;
  logic [1:0] fault_kind;
  logic [31:0] fault_cause;

  radix_walker i_radix_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .acc(acc), .ir_en(ir_en), .dr_en(dr_en),
    .pid(pid), .part_entry(part), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .real_mode(real_mode), .real_addr(real_addr),
    .page_shift(page_shift), .leaf_pte(leaf_pte), .leaf_addr(leaf_addr), .fault(fault),
    .fault_kind(fault_kind), .fault_cause(fault_cause), .fault_addr(fault_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [63:0] mem [logic [63:0]];
  int unsigned tot_reads = 0;
  int unsigned rcnt = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  function automatic logic [63:0] mrd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mrd(mem_req_addr);
      tot_reads     <= tot_reads + 1;
    end
    rcnt          <= rcnt + 1;
    mem_req_ready <= (rcnt % 3) != 1;
  end

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model outputs
  bit m_done, m_real;
  logic [1:0] m_kind;
  logic [31:0] m_cause;
  logic [63:0] m_faddr, m_raddr, m_pte, m_paddr;
  int m_shift, m_reads;

  task automatic sfault(input logic [31:0] c, input logic [1:0] a, input logic [63:0] e);
    m_done  = 0;
    m_kind  = (a == 2) ? 2'd1 : 2'd0;
    m_cause = c | ((a == 1) ? 32'h0200_0000 : 32'h0);
    m_faddr = (a == 2) ? 64'd0 : e;
  endtask

  task automatic ref_walk(input logic [63:0] e, input logic [1:0] a, input bit ir, input bit dr,
                          input logic [19:0] p, input logic [63:0] pt);
    logic [63:0] tsize, off, d, base, idx, addr, lowm, ew;
    int left, bits;
    m_reads = 0; m_real = 0; m_pte = 0; m_paddr = 0; m_raddr = 0; m_shift = 0;
    m_cause = 0; m_faddr = 0; m_kind = 0; m_done = 0;
    if ((a == 2) ? !ir : !dr) begin
      m_done = 1; m_real = 1; m_raddr = {4'h0, e[59:0]}; return;
    end
    if (e[63:62] == 2'b01 || e[63:62] == 2'b10) begin
      m_kind = (a == 2) ? 2'd3 : 2'd2; m_faddr = (a == 2) ? 64'd0 : e; return;
    end
    off = (e[63:62] == 2'b11) ? 64'd0 : {40'd0, p, 4'd0};
    tsize = 64'd1 << (int'(pt[4:0]) + 12);
    if (off >= tsize) begin sfault(32'h4000_0000, a, e); return; end
    d = mrd({4'h0, pt[59:12], 12'h000} + off);
    m_reads++;
    left = int'({d[62:61], d[7:5]}) + 31;
    base = {4'h0, d[59:8], 8'h00};
    bits = int'(d[4:0]);
    ew = {2'b00, e[61:0]};
    for (int lv = 0; lv <= 8; lv++) begin
      if (lv == 8 || bits < 5 || bits > left) begin sfault(32'h0008_0000, a, e); return; end
      idx = (ew >> (left - bits)) % (64'd1 << bits);
      addr = base + idx * 8;
      d = mrd(addr);
      m_reads++;
      if (!d[63]) begin sfault(32'h4000_0000, a, e); return; end
      left = left - bits;
      if (d[62]) begin
        lowm = (64'd1 << left) - 1;
        m_raddr = ({7'd0, d[56:12], 12'h000} & ~lowm) | (ew & lowm);
        m_shift = left; m_pte = d; m_paddr = addr; m_done = 1;
        return;
      end
      base = {4'h0, d[59:8], 8'h00};
      bits = int'(d[4:0]);
    end
  endtask

  task automatic run_walk(input string tag, input logic [63:0] t_ea, input logic [1:0] t_acc,
                          input bit t_ir, input bit t_dr, input logic [19:0] t_pid,
                          input logic [63:0] t_part);
    int unsigned r0;
    int w;
    ref_walk(t_ea, t_acc, t_ir, t_dr, t_pid, t_part);
    @(negedge clk);
    ea = t_ea; acc = t_acc; ir_en = t_ir; dr_en = t_dr; pid = t_pid; part = t_part;
    r0 = tot_reads;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!(done || fault) && w < 2000) begin @(negedge clk); w++; end
    if (w >= 2000) begin chk({tag, " timeout"}, 0, 0, 1); return; end
    chk({tag, " end type"}, done == m_done && fault == !m_done, {fault, done}, {!m_done, m_done});
    if (m_done) begin
      chk({tag, " real_mode"}, real_mode == m_real, real_mode, m_real);
      chk({tag, " real_addr"}, real_addr == m_raddr, real_addr, m_raddr);
      if (!m_real) begin
        chk({tag, " page_shift"}, page_shift == 7'(m_shift), page_shift, m_shift);
        chk({tag, " leaf_pte"}, leaf_pte == m_pte, leaf_pte, m_pte);
        chk({tag, " leaf_addr"}, leaf_addr == m_paddr, leaf_addr, m_paddr);
      end
    end else begin
      chk({tag, " fault_kind"}, fault_kind == m_kind, fault_kind, m_kind);
      chk({tag, " fault_cause"}, fault_cause == m_cause, fault_cause, m_cause);
      chk({tag, " fault_addr"}, fault_addr == m_faddr, fault_addr, m_faddr);
    end
    chk({tag, " read count"}, (tot_reads - r0) == m_reads, tot_reads - r0, m_reads);
    @(negedge clk);
    chk("R11 single-cycle end", !done && !fault && !busy, {busy, fault, done}, 0);
  endtask

  // tree construction
  int cfg_nls[0:9];
  int cfg_rts, cfg_depth;
  logic [63:0] next_tab = 64'h0000_0000_0100_0000;

  function automatic logic [63:0] mk_leaf(input logic [63:0] rpn);
    return 64'hC000_0000_0000_0000 | (rpn & RPN_M) | 64'h10E;
  endfunction

  task automatic alloc(output logic [63:0] b);
    b = next_tab;
    next_tab = next_tab + 64'h0010_0000;
  endtask

  task automatic map_page(input logic [19:0] p, input logic [63:0] e, input logic [63:0] leafv);
    logic [63:0] pe, base, idx, a, ew, nt;
    logic [4:0] r;
    int left, bits;
    pe = PRT_BASE + {40'd0, p, 4'd0};
    if (!mem.exists(pe)) begin
      alloc(nt);
      r = 5'(cfg_rts - 31);
      mem[pe] = nt | {1'b0, r[4:3], 61'd0} | {56'd0, r[2:0], 5'd0} | 64'(cfg_nls[0]);
    end
    base = mem[pe] & 64'h0FFF_FFFF_FFFF_FF00;
    left = cfg_rts;
    ew = {2'b00, e[61:0]};
    for (int lv = 0; lv < cfg_depth; lv++) begin
      bits = cfg_nls[lv];
      idx = (ew >> (left - bits)) % (64'd1 << bits);
      a = base + idx * 8;
      left = left - bits;
      if (lv == cfg_depth - 1) mem[a] = leafv;
      else if (mem.exists(a) && mem[a][63] && !mem[a][62]) base = mem[a] & 64'h0FFF_FFFF_FFFF_FF00;
      else begin
        alloc(nt);
        mem[a] = 64'h8000_0000_0000_0000 | nt | 64'(cfg_nls[lv + 1]);
        base = nt;
      end
    end
  endtask

  localparam logic [63:0] PART_MAIN = PRT_BASE | 64'h4;
  logic [63:0] ea_list [0:11];

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset idle", !done && !fault && !busy && !mem_req_valid,
        {mem_req_valid, busy, fault, done}, 0);
    rst_n = 1'b1;

    // A: four-level 4K tree for pid 5
    cfg_rts = 52; cfg_depth = 4;
    cfg_nls[0] = 13; cfg_nls[1] = 9; cfg_nls[2] = 9; cfg_nls[3] = 9;
    for (int i = 0; i < 12; i++) begin
      ea_list[i] = (64'h0000_0ABC_DE01_2000 + 64'(i) * 64'h0000_0013_5790_2468) & 64'h000F_FFFF_FFFF_FFFF;
      map_page(20'd5, ea_list[i], mk_leaf(64'h0000_0040_0000_0000 + 64'(i) * 64'h0000_0000_1234_5000));
    end
    for (int i = 0; i < 12; i++) begin
      run_walk("R9 leaf 4K", ea_list[i], 2'(i % 3), 1'b1, 1'b1, 20'd5, PART_MAIN);
      run_walk("R6 in-page offset", ea_list[i] + 64'h123, 2'((i + 1) % 3), 1'b1, 1'b1, 20'd5, PART_MAIN);
      run_walk("R8 unmapped neighbour", ea_list[i] ^ 64'h0000_0000_0020_0000, 2'(i % 3), 1'b1, 1'b1,
               20'd5, PART_MAIN);
    end

    // R1: real mode across relocation bits and access kinds
    for (int a = 0; a < 3; a++)
      for (int m = 0; m < 4; m++)
        run_walk("R1 real mode", ea_list[a] | 64'hF000_0000_0000_0000 * 64'(m & 1 & (a == 0 ? 0 : 1)),
                 2'(a), m[0], m[1], 20'd5, PART_MAIN);
    run_walk("R1 real top bits", 64'hFEDC_BA98_7654_3210, 2'd0, 1'b1, 1'b0, 20'd5, PART_MAIN);
    run_walk("R1 real fetch", 64'hA000_0000_1234_5678, 2'd2, 1'b0, 1'b1, 20'd5, PART_MAIN);

    // R2: segment faults in quadrants 1 and 2
    for (int a = 0; a < 3; a++) begin
      run_walk("R2 quadrant 1", 64'h4000_0000_0000_1000 | ea_list[a], 2'(a), 1'b1, 1'b1, 20'd5, PART_MAIN);
      run_walk("R2 quadrant 2", 64'h8000_0000_0000_2000 | ea_list[a], 2'(a), 1'b1, 1'b1, 20'd5, PART_MAIN);
    end

    // R3: quadrant 3 uses identifier 0
    for (int i = 0; i < 4; i++)
      map_page(20'd0, 64'hC000_0000_0000_0000 | ea_list[i], mk_leaf(64'h0000_0077_0000_0000 + 64'(i) * 64'h1000));
    for (int i = 0; i < 4; i++) begin
      run_walk("R3 quadrant 3", 64'hC000_0000_0000_0000 | ea_list[i], 2'(i % 3), 1'b1, 1'b1, 20'd5, PART_MAIN);
      run_walk("R3 quadrant 0 pid", ea_list[i], 2'(i % 3), 1'b1, 1'b1, 20'd5, PART_MAIN);
    end

    // R5: large pages and a smaller total size
    cfg_depth = 2; cfg_nls[0] = 13; cfg_nls[1] = 9;
    for (int i = 0; i < 4; i++) map_page(20'd7, ea_list[i], mk_leaf(64'h0000_00C0_0000_0000 + 64'(i) * 64'h4000_0000));
    for (int i = 0; i < 4; i++) run_walk("R5 1G page", ea_list[i] + 64'h3_4567, 2'(i % 3), 1'b1, 1'b1, 20'd7, PART_MAIN);
    cfg_rts = 40; cfg_depth = 3; cfg_nls[0] = 10; cfg_nls[1] = 9; cfg_nls[2] = 9;
    for (int i = 0; i < 4; i++) map_page(20'd8, ea_list[i] & 64'hFF_FFFF_FFFF, mk_leaf(64'h0000_0001_0000_0000 + 64'(i) * 64'h2000));
    for (int i = 0; i < 4; i++) run_walk("R5 40-bit tree", ea_list[i] & 64'hFF_FFFF_FFFF, 2'(i % 3), 1'b1, 1'b1, 20'd8, PART_MAIN);

    // R7: widths too small or too large
    mem[PRT_BASE + 64'd9 * 16] = 64'h0000_0000_0F00_0000 | 64'h0000_0000_0000_00A0 | 64'd4;
    for (int a = 0; a < 3; a++) run_walk("R7 root width 4", ea_list[a], 2'(a), 1'b1, 1'b1, 20'd9, PART_MAIN);
    cfg_rts = 52; cfg_depth = 1; cfg_nls[0] = 13; cfg_nls[1] = 3;
    map_page(20'd10, ea_list[0], 64'h8000_0000_0E00_0000 | 64'd3);
    run_walk("R7 level width 3", ea_list[0], 2'd1, 1'b1, 1'b1, 20'd10, PART_MAIN);
    cfg_rts = 31; cfg_nls[0] = 5;
    map_page(20'd13, ea_list[1] & 64'h7FFF_FFFF, 64'h8000_0000_0D00_0000 | 64'd30);
    run_walk("R7 width above remaining", ea_list[1] & 64'h7FFF_FFFF, 2'd0, 1'b1, 1'b1, 20'd13, PART_MAIN);

    // R8 and R10: invalid leaf with each access kind
    cfg_rts = 52; cfg_depth = 4; cfg_nls[0] = 13; cfg_nls[1] = 9; cfg_nls[2] = 9; cfg_nls[3] = 9;
    map_page(20'd14, ea_list[2], 64'h4000_0000_5555_5000);
    for (int a = 0; a < 3; a++) run_walk("R10 invalid leaf cause", ea_list[2] + 64'h40, 2'(a), 1'b1, 1'b1, 20'd14, PART_MAIN);

    // R12: exactly eight levels pass, nine levels fault
    cfg_depth = 8;
    for (int k = 0; k < 9; k++) cfg_nls[k] = 5;
    map_page(20'd11, ea_list[3], mk_leaf(64'h0000_0002_2222_2000));
    for (int a = 0; a < 3; a++) run_walk("R12 eight levels", ea_list[3], 2'(a), 1'b1, 1'b1, 20'd11, PART_MAIN);
    cfg_depth = 9;
    map_page(20'd12, ea_list[4], mk_leaf(64'h0000_0003_3333_3000));
    for (int a = 0; a < 3; a++) run_walk("R12 nine levels", ea_list[4], 2'(a), 1'b1, 1'b1, 20'd12, PART_MAIN);

    // R4: process table bounds at the exact edge
    for (int s = 0; s < 4; s++) begin
      run_walk("R4 last in bounds", ea_list[5], 2'(s % 3), 1'b1, 1'b1, 20'((256 << s) - 1),
               64'h0000_0000_0800_0000 | 64'(s));
      run_walk("R4 first out of bounds", ea_list[5], 2'(s % 3), 1'b1, 1'b1, 20'(256 << s),
               64'h0000_0000_0800_0000 | 64'(s));
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule